// File: doc/BRIEF.md
# Two-Port Storage Host Register File with Interrupt Aggregation

This block is the software-visible register bank of a serial storage host controller that serves two device ports. A 32-bit access port carries reads and writes. The low 4 KiB of the address selects one of two windows. The first is a small global window that holds identification constants and a summary of pending interrupts. The second is a per-port window of 128 bytes per port. Each port window holds the command-list base, the receive-area base, the interrupt status and its mask, a command register, and a command-issue register.

A completion input comes from the command engine. It names a port and gives a vector of event bits, which are merged into that port's interrupt status. Every port whose masked status is nonzero sets its bit in a sticky global status word. A single level interrupt output is high while that word is nonzero. Writes to a port's command or command-issue register send a one-cycle start pulse to the command engine, but only while that port's start bit is set.

Top module: `stor_host_regfile`

## Requirements
- R1: After reset the global words read capabilities 0x00001F02 (offset 0x00), control 0x80000000 (0x04), global status 0 (0x08), implemented-ports 0x00000001 (0x0C) and version 0x00010100 (0x10). Every port register reads 0, irqOut is low and startReq is zero.
- R2: Only address bits [11:0] are decoded, so addresses 4 KiB apart alias. Offsets from 0x14 to 0xFF and from 0x200 up read zero, and writes to them change nothing.
- R3: Offsets 0x100–0x17F address port 0 and 0x180–0x1FF address port 1, with the register given by offset & 0x7F. The command-list base low and high (0x00, 0x04), the receive base low and high (0x08, 0x0C), the mask (0x14) and command-issue (0x38) read back what was written, and only in the addressed port.
- R4: A write whose address bits [1:0] are not 00 changes no register and raises no start pulse.
- R5: Writing port status (0x10) clears each bit written as 1. A completion (doneValid, donePort, doneBits) ORs doneBits into that port's status. When both happen in the same cycle, the completion's bits are set.
- R6: After each clock edge, global status bit p is set if port p's status AND mask is nonzero. The bit stays set after the port status is cleared. Writing 1 to it at 0x08 clears it, unless port p is still pending, in which case it is set again at once.
- R7: irqOut is high exactly when global status is nonzero. It changes in the cycle after the edge that updates global status.
- R8: A write to the port command register (0x18) stores wdata AND 0x0100C01F, so only bits 24, 15, 14, 4, 3, 2, 1 and 0 are kept.
- R9: The link-status register (0x28) reads 3 on port 0 while driveAttached is high. It reads 0 on port 0 otherwise, and 0 on port 1 always.
- R10: startReq[p] goes high for exactly one cycle after a write to port p's command register whose bit 0 is 1, or after a write to its command-issue register while its stored command bit 0 is 1. No other write produces a pulse.
- R11: The capabilities, control, implemented-ports and version words ignore writes.
- R12: Read data appears on regRdata in the cycle after a read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte address; bits [11:0] decoded |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| driveAttached | input | 1 | A drive is present on port 0 |
| doneValid | input | 1 | Completion event strobe |
| donePort | input | PIDX_W | Port index of the completion |
| doneBits | input | 32 | Status bits to set on that port |
| startReq | output | NPORTS | One-cycle start pulse per port |
| irqOut | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is a global status bit that disagrees with its port. It can be left set after the port has been cleared, or it can be set again straight after software cleared it. The stimulus builds both cases on purpose. A completion arrives on a masked port, and the mask is opened later. The global bit is then cleared while the port is still pending, and again after the port status has been cleared. The bench also drives a clearing status write and a completion in the same cycle to show which one wins.

// File: rtl/stor_host_pkg.sv
package stor_host_pkg;

  localparam int REG_W = 32;
  localparam int WIN_W = 12;

  localparam logic [WIN_W-1:0] GLOBAL_END = 12'h020;
  localparam logic [WIN_W-1:0] PORT_BASE  = 12'h100;
  localparam int               PORT_SPAN  = 128;

  // global word offsets (low five bits)
  localparam logic [4:0] G_CAP  = 5'h00;
  localparam logic [4:0] G_CTL  = 5'h04;
  localparam logic [4:0] G_STAT = 5'h08;
  localparam logic [4:0] G_IMPL = 5'h0C;
  localparam logic [4:0] G_VER  = 5'h10;

  // per-port word offsets
  localparam logic [6:0] P_LST_LO = 7'h00;
  localparam logic [6:0] P_LST_HI = 7'h04;
  localparam logic [6:0] P_RX_LO  = 7'h08;
  localparam logic [6:0] P_RX_HI  = 7'h0C;
  localparam logic [6:0] P_STAT   = 7'h10;
  localparam logic [6:0] P_MASK   = 7'h14;
  localparam logic [6:0] P_CMD    = 7'h18;
  localparam logic [6:0] P_LINK   = 7'h28;
  localparam logic [6:0] P_ISSUE  = 7'h38;

  localparam logic [REG_W-1:0] CAP_VAL   = 32'h0000_1F02;
  localparam logic [REG_W-1:0] GCTL_VAL  = 32'h8000_0000;
  localparam logic [REG_W-1:0] IMPL_VAL  = 32'h0000_0001;
  localparam logic [REG_W-1:0] VER_VAL   = 32'h0001_0100;
  localparam logic [REG_W-1:0] LINK_UP   = 32'h0000_0003;
  localparam logic [REG_W-1:0] CMD_KEEP  = 32'h0100_C01F;
  localparam int               START_BIT = 0;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_CAP, SEL_GCTL, SEL_GSTAT, SEL_IMPL, SEL_VER,
    SEL_LST_LO, SEL_LST_HI, SEL_RX_LO, SEL_RX_HI, SEL_STAT,
    SEL_MASK, SEL_CMD, SEL_LINK, SEL_ISSUE
  } rdSel_e;

  typedef struct packed {
    logic wrLstLo;
    logic wrLstHi;
    logic wrRxLo;
    logic wrRxHi;
    logic clrStat;
    logic wrMask;
    logic wrCmd;
    logic wrIssue;
  } portStb_t;

  typedef struct packed {
    logic   rdEn;
    rdSel_e rdSel;
    logic   clrGlobal;
  } hostStb_t;

endpackage

// File: rtl/stor_host_ctrl.sv
module stor_host_ctrl
  import stor_host_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int NPORTS = 2,
  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output portStb_t          portStb [NPORTS],
  output hostStb_t          hostStb,
  output logic [PIDX_W-1:0] portIdx
);

  localparam int PORT_END = int'(PORT_BASE) + NPORTS * PORT_SPAN;

  logic [WIN_W-1:0] off;
  logic [WIN_W-1:0] rel;
  logic [4:0]       gWord;
  logic [6:0]       pWord;
  logic             inGlobal;
  logic             inPort;
  logic             wrOk;
  portStb_t         hit;

  assign off      = regAddr[WIN_W-1:0];
  assign rel      = off - PORT_BASE;
  assign gWord    = {off[4:2], 2'b00};
  assign pWord    = {off[6:2], 2'b00};
  assign inGlobal = off < GLOBAL_END;
  assign inPort   = (off >= PORT_BASE) && (int'(off) < PORT_END);
  assign portIdx  = rel[7 +: PIDX_W];
  assign wrOk     = regValid && regWrite && (off[1:0] == 2'b00);

  always_comb begin
    hostStb.rdEn      = regValid && !regWrite;
    hostStb.rdSel     = SEL_ZERO;
    hostStb.clrGlobal = 1'b0;
    hit               = '0;
    if (inGlobal) begin
      case (gWord)
        G_CAP:  hostStb.rdSel = SEL_CAP;
        G_CTL:  hostStb.rdSel = SEL_GCTL;
        G_STAT: begin
          hostStb.rdSel     = SEL_GSTAT;
          hostStb.clrGlobal = wrOk;
        end
        G_IMPL: hostStb.rdSel = SEL_IMPL;
        G_VER:  hostStb.rdSel = SEL_VER;
        default: hostStb.rdSel = SEL_ZERO;
      endcase
    end else if (inPort) begin
      case (pWord)
        P_LST_LO: begin hostStb.rdSel = SEL_LST_LO; hit.wrLstLo = wrOk; end
        P_LST_HI: begin hostStb.rdSel = SEL_LST_HI; hit.wrLstHi = wrOk; end
        P_RX_LO:  begin hostStb.rdSel = SEL_RX_LO;  hit.wrRxLo  = wrOk; end
        P_RX_HI:  begin hostStb.rdSel = SEL_RX_HI;  hit.wrRxHi  = wrOk; end
        P_STAT:   begin hostStb.rdSel = SEL_STAT;   hit.clrStat = wrOk; end
        P_MASK:   begin hostStb.rdSel = SEL_MASK;   hit.wrMask  = wrOk; end
        P_CMD:    begin hostStb.rdSel = SEL_CMD;    hit.wrCmd   = wrOk; end
        P_LINK:   hostStb.rdSel = SEL_LINK;
        P_ISSUE:  begin hostStb.rdSel = SEL_ISSUE;  hit.wrIssue = wrOk; end
        default:  hostStb.rdSel = SEL_ZERO;
      endcase
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_route
    assign portStb[p] = (portIdx == PIDX_W'(p)) ? hit : '0;
  end

endmodule

// File: rtl/stor_host_dp.sv
module stor_host_dp
  import stor_host_pkg::*;
#(
  parameter  int NPORTS = 2,
  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStb_t          portStb [NPORTS],
  input  hostStb_t          hostStb,
  input  logic [PIDX_W-1:0] portIdx,
  input  logic [REG_W-1:0]  wdata,
  input  logic              driveAttached,
  input  logic              doneValid,
  input  logic [PIDX_W-1:0] donePort,
  input  logic [REG_W-1:0]  doneBits,
  output logic [REG_W-1:0]  rdata,
  output logic [NPORTS-1:0] startReq,
  output logic              irqOut
);

  logic [REG_W-1:0] lstLo [NPORTS];
  logic [REG_W-1:0] lstHi [NPORTS];
  logic [REG_W-1:0] rxLo  [NPORTS];
  logic [REG_W-1:0] rxHi  [NPORTS];
  logic [REG_W-1:0] stat  [NPORTS];
  logic [REG_W-1:0] mask  [NPORTS];
  logic [REG_W-1:0] cmd   [NPORTS];
  logic [REG_W-1:0] issue [NPORTS];

  logic [REG_W-1:0] statD [NPORTS];
  logic [REG_W-1:0] maskD [NPORTS];
  logic [REG_W-1:0] cmdD  [NPORTS];

  logic [NPORTS-1:0] pend;
  logic [NPORTS-1:0] startD;
  logic [NPORTS-1:0] gstat;
  logic [NPORTS-1:0] gstatD;
  logic [NPORTS-1:0] gclr;
  logic [REG_W-1:0]  rdMux;

  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      statD[p] = (stat[p] & ~(portStb[p].clrStat ? wdata : '0)) |
                 ((doneValid && donePort == PIDX_W'(p)) ? doneBits : '0);
      maskD[p] = portStb[p].wrMask ? wdata : mask[p];
      cmdD[p]  = portStb[p].wrCmd ? (wdata & CMD_KEEP) : cmd[p];
      pend[p]  = |(statD[p] & maskD[p]);
      startD[p] = (portStb[p].wrCmd && wdata[START_BIT]) ||
                  (portStb[p].wrIssue && cmd[p][START_BIT]);
    end
  end

  assign gclr   = hostStb.clrGlobal ? wdata[NPORTS-1:0] : '0;
  assign gstatD = (gstat & ~gclr) | pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NPORTS; p++) begin
        lstLo[p] <= '0;
        lstHi[p] <= '0;
        rxLo[p]  <= '0;
        rxHi[p]  <= '0;
        stat[p]  <= '0;
        mask[p]  <= '0;
        cmd[p]   <= '0;
        issue[p] <= '0;
      end
      gstat    <= '0;
      startReq <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (portStb[p].wrLstLo) lstLo[p] <= wdata;
        if (portStb[p].wrLstHi) lstHi[p] <= wdata;
        if (portStb[p].wrRxLo)  rxLo[p]  <= wdata;
        if (portStb[p].wrRxHi)  rxHi[p]  <= wdata;
        if (portStb[p].wrIssue) issue[p] <= wdata;
        stat[p] <= statD[p];
        mask[p] <= maskD[p];
        cmd[p]  <= cmdD[p];
      end
      gstat    <= gstatD;
      startReq <= startD;
    end
  end

  always_comb begin
    case (hostStb.rdSel)
      SEL_CAP:    rdMux = CAP_VAL;
      SEL_GCTL:   rdMux = GCTL_VAL;
      SEL_GSTAT:  rdMux = REG_W'(gstat);
      SEL_IMPL:   rdMux = IMPL_VAL;
      SEL_VER:    rdMux = VER_VAL;
      SEL_LST_LO: rdMux = lstLo[portIdx];
      SEL_LST_HI: rdMux = lstHi[portIdx];
      SEL_RX_LO:  rdMux = rxLo[portIdx];
      SEL_RX_HI:  rdMux = rxHi[portIdx];
      SEL_STAT:   rdMux = stat[portIdx];
      SEL_MASK:   rdMux = mask[portIdx];
      SEL_CMD:    rdMux = cmd[portIdx];
      SEL_LINK:   rdMux = (portIdx == '0 && driveAttached) ? LINK_UP : '0;
      SEL_ISSUE:  rdMux = issue[portIdx];
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdata <= '0;
    else if (hostStb.rdEn) rdata <= rdMux;
  end

  assign irqOut = |gstat;

endmodule

// File: rtl/stor_host_regfile.sv
module stor_host_regfile
  import stor_host_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int NPORTS = 2,
  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              driveAttached,
  input  logic              doneValid,
  input  logic [PIDX_W-1:0] donePort,
  input  logic [31:0]       doneBits,
  output logic [NPORTS-1:0] startReq,
  output logic              irqOut
);

  portStb_t          portStb [NPORTS];
  hostStb_t          hostStb;
  logic [PIDX_W-1:0] portIdx;

  stor_host_ctrl #(.ADDR_W(ADDR_W), .NPORTS(NPORTS)) u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .portStb  (portStb),
    .hostStb  (hostStb),
    .portIdx  (portIdx)
  );

  stor_host_dp #(.NPORTS(NPORTS)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .portStb       (portStb),
    .hostStb       (hostStb),
    .portIdx       (portIdx),
    .wdata         (regWdata),
    .driveAttached (driveAttached),
    .doneValid     (doneValid),
    .donePort      (donePort),
    .doneBits      (doneBits),
    .rdata         (regRdata),
    .startReq      (startReq),
    .irqOut        (irqOut)
  );

endmodule

// File: rtl/stor_host_regfile_chk.sv
module stor_host_regfile_chk #(
  parameter  int ADDR_W = 32,
  parameter  int NPORTS = 2,
  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              regValid,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              driveAttached,
  input logic              doneValid,
  input logic [PIDX_W-1:0] donePort,
  input logic [31:0]       doneBits,
  input logic [NPORTS-1:0] startReq,
  input logic              irqOut
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!irqOut && startReq == '0));

  // R10
  start_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq != '0) |-> $past(regValid && regWrite && regAddr[1:0] == 2'b00));

  // R4
  misaligned_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(regValid && regWrite && regAddr[1:0] != 2'b00) |-> (startReq == '0));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(regValid && regWrite) && !$past(doneValid)) |-> $stable(irqOut));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regValid && !regWrite) |-> $stable(regRdata));

endmodule

bind stor_host_regfile stor_host_regfile_chk #(.ADDR_W(ADDR_W), .NPORTS(NPORTS)) u_chk (.*);

// File: tb/stor_host_regfile_tb.sv
`timescale 1ns/1ps
module stor_host_regfile_tb;

  localparam int NPORTS = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [31:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        driveAttached = 1'b0;
  logic        doneValid = 1'b0;
  logic [0:0]  donePort = '0;
  logic [31:0] doneBits = '0;
  logic [1:0]  startReq;
  logic        irqOut;

  int  errors = 0;
  int  checks = 0;
  bit  finished = 0;
  logic rdPendQ = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] addr;
    string       req;
  } sbItem_t;
  sbItem_t sb[$];

  always #2.5 clk = ~clk;

  stor_host_regfile #(.ADDR_W(32), .NPORTS(NPORTS)) u_dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .driveAttached(driveAttached), .doneValid(doneValid), .donePort(donePort),
    .doneBits(doneBits), .startReq(startReq), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // monitor: compares read data against scoreboard entries
  always @(posedge clk) rdPendQ <= regValid && !regWrite;

  always @(negedge clk) begin
    if (rdPendQ) begin
      if (sb.size() == 0) begin
        chk("scoreboard-empty", 32'h1, 32'h0);
      end else begin
        sbItem_t it;
        it = sb.pop_front();
        chk($sformatf("%s @0x%0h", it.req, it.addr), regRdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string req);
    sbItem_t it;
    it.exp = exp; it.addr = a; it.req = req;
    sb.push_back(it);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
  endtask

  task automatic done(input logic [0:0] p, input logic [31:0] bits);
    doneValid = 1'b1; donePort = p; doneBits = bits;
    @(negedge clk);
    doneValid = 1'b0; doneBits = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);
    chk("R1 startReq", {30'b0, startReq}, 32'h0);
    rd(32'h000, 32'h0000_1F02, "R1 cap");
    rd(32'h004, 32'h8000_0000, "R1 ctl");
    rd(32'h008, 32'h0, "R1 gstat");
    rd(32'h00C, 32'h1, "R1 impl");
    rd(32'h010, 32'h0001_0100, "R1 ver");
    rd(32'h110, 32'h0, "R1 port0 stat");
    rd(32'h198, 32'h0, "R1 port1 cmd");

    // R11 read-only globals
    wr(32'h000, 32'hFFFF_FFFF);
    wr(32'h004, 32'h0);
    rd(32'h000, 32'h0000_1F02, "R11 cap");
    rd(32'h004, 32'h8000_0000, "R11 ctl");

    // R2 aliasing and unmapped space
    rd(32'h1000, 32'h0000_1F02, "R2 alias");
    rd(32'h014, 32'h0, "R2 unused global");
    rd(32'h050, 32'h0, "R2 gap");
    wr(32'h200, 32'hDEAD_BEEF);
    rd(32'h200, 32'h0, "R2 above window");

    // R3 port slots and registers
    wr(32'h100, 32'h1234_5600);
    wr(32'h180, 32'hAAAA_0000);
    wr(32'h1108, 32'hBEEF_0000);
    wr(32'h18C, 32'h0000_0077);
    wr(32'h1B8, 32'h0000_0005);
    rd(32'h100, 32'h1234_5600, "R3 p0 lst");
    rd(32'h180, 32'hAAAA_0000, "R3 p1 lst");
    rd(32'h108, 32'hBEEF_0000, "R3 p0 rx via alias");
    rd(32'h188, 32'h0, "R3 p1 rx untouched");
    rd(32'h18C, 32'h0000_0077, "R3 p1 rxhi");
    rd(32'h1B8, 32'h0000_0005, "R3 p1 issue");
    rd(32'h138, 32'h0, "R3 p0 issue untouched");

    // R4 misaligned write ignored
    wr(32'h102, 32'hFFFF_FFFF);
    chk("R4 no pulse", {30'b0, startReq}, 32'h0);
    wr(32'h119, 32'hFFFF_FFFF);
    chk("R4 no pulse cmd", {30'b0, startReq}, 32'h0);
    rd(32'h100, 32'h1234_5600, "R4 lst kept");
    rd(32'h118, 32'h0, "R4 cmd kept");

    // R8 / R10 command write
    wr(32'h118, 32'hFFFF_FFFF);
    chk("R10 pulse on cmd", {30'b0, startReq}, 32'h1);
    rd(32'h118, 32'h0100_C01F, "R8 cmd mask");
    chk("R10 single cycle", {30'b0, startReq}, 32'h0);
    wr(32'h138, 32'h1);
    chk("R10 pulse on issue", {30'b0, startReq}, 32'h1);
    idle(1);
    chk("R10 pulse ends", {30'b0, startReq}, 32'h0);
    wr(32'h198, 32'h0000_0010);
    chk("R10 cmd w/o start", {30'b0, startReq}, 32'h0);
    wr(32'h1B8, 32'h3);
    chk("R10 issue w/o start", {30'b0, startReq}, 32'h0);
    rd(32'h198, 32'h0000_0010, "R8 p1 cmd");

    // R9 link status
    driveAttached = 1'b1;
    rd(32'h128, 32'h3, "R9 p0 attached");
    rd(32'h1A8, 32'h0, "R9 p1");
    driveAttached = 1'b0;
    rd(32'h128, 32'h0, "R9 p0 detached");

    // R5 / R6 / R7 status and interrupt
    wr(32'h114, 32'h1);
    chk("R7 irq idle", {31'b0, irqOut}, 32'h0);
    done(1'b0, 32'h5);
    chk("R7 irq raised", {31'b0, irqOut}, 32'h1);
    rd(32'h110, 32'h5, "R5 completion set");
    rd(32'h008, 32'h1, "R6 gstat p0");
    wr(32'h110, 32'h1);
    rd(32'h110, 32'h4, "R5 w1c port");
    rd(32'h008, 32'h1, "R6 sticky");
    chk("R7 irq sticky", {31'b0, irqOut}, 32'h1);
    wr(32'h008, 32'h1);
    chk("R7 irq dropped", {31'b0, irqOut}, 32'h0);
    rd(32'h008, 32'h0, "R6 cleared");

    done(1'b1, 32'h8);
    chk("R6 masked no irq", {31'b0, irqOut}, 32'h0);
    rd(32'h190, 32'h8, "R5 p1 status");
    wr(32'h194, 32'h8);
    chk("R7 irq on unmask", {31'b0, irqOut}, 32'h1);
    rd(32'h008, 32'h2, "R6 gstat p1");
    wr(32'h008, 32'h2);
    rd(32'h008, 32'h2, "R6 reassert while pending");
    chk("R7 irq stays", {31'b0, irqOut}, 32'h1);
    wr(32'h190, 32'h8);
    wr(32'h008, 32'h2);
    rd(32'h008, 32'h0, "R6 final clear");
    chk("R7 irq low", {31'b0, irqOut}, 32'h0);

    // R5 set wins over clear in same cycle
    regValid = 1'b1; regWrite = 1'b1; regAddr = 32'h110; regWdata = 32'h4;
    doneValid = 1'b1; donePort = 1'b0; doneBits = 32'h4;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0; doneValid = 1'b0; doneBits = '0;
    rd(32'h110, 32'h4, "R5 set wins");
    rd(32'h190, 32'h0, "R5 other port untouched");

    // R12 read data holds
    rd(32'h00C, 32'h1, "R12 read");
    idle(2);
    chk("R12 hold", regRdata, 32'h1);

    idle(2);
    if (sb.size() != 0) chk("scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule